// File: doc/BRIEF.md
# Four-Bit Function-Select ALU Slice

This block is a purely combinational arithmetic and logic slice for two four-bit operands. A four-bit function code and a mode bit together pick one of 32 fixed operations. In logic mode every result bit depends only on the matching operand bits, and no carry moves between bit positions. In arithmetic mode the slice forms the sum of two per-bit terms that the function code derives from the operands, plus the carry input. Subtraction uses the ones complement of B, so a carry out means that no borrow occurred.

Slices are chained in one of two ways. The carry output can feed the carry input of the next slice, or the group propagate and generate outputs can feed an external lookahead unit. Those two outputs never depend on the carry input. The all-ones flag shows whether every result bit is set. In the decrement-subtract operation this flag marks A equal to B, and the carry output then orders the two operands.

Top module: `alu4_slice`

## Requirements
- R1: With `logic_mode`=1, `result` is bitwise on A and B by `func_sel` code: 0 ~A, 1 ~(A|B), 2 ~A&B, 3 all zeros, 4 ~(A&B), 5 ~B, 6 A^B, 7 A&~B, 8 ~A|B, 9 ~(A^B), A B, B A&B, C all ones, D A|~B, E A|B, F A.
- R2: With `logic_mode`=0 and `carry_in`=0, `result` is the low four bits of X+Y, where (X,Y) by code is: 0 (A,0), 1 (A|B,0), 2 (A|~B,0), 3 (15,0), 4 (A,A&~B), 5 (A|B,A&~B), 6 (A,~B), 7 (A&~B,15), 8 (A,A&B), 9 (A,B), A (A|~B,A&B), B (A&B,15), C (A,A), D (A|B,A), E (A|~B,A), F (A,15).
- R3: With `logic_mode`=0, asserting `carry_in` adds exactly one to the R2 result (modulo 16).
- R4: With `logic_mode`=0, `carry_out` is bit 4 of the five-bit sum X+Y+`carry_in`.
- R5: With `logic_mode`=1, `carry_out` is 0, and `carry_in` has no effect on `result`.
- R6: `grp_gen` is 1 exactly when X+Y is 16 or more, whatever `carry_in` and `logic_mode` are.
- R7: `grp_gen` OR `grp_prop` is 1 exactly when X+Y is 15 or more, whatever `carry_in` and `logic_mode` are.
- R8: `all_ones` is 1 exactly when all four `result` bits are 1. With code 6, `logic_mode`=0 and `carry_in`=0, this means A equals B.
- R9: With code 6, `logic_mode`=0 and `carry_in`=1, `result` is A-B modulo 16, and `carry_out` is 1 exactly when A is greater than or equal to B (unsigned).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 4 | Operand A |
| opnd_b | input | 4 | Operand B |
| func_sel | input | 4 | Function code; bits 1:0 pick the X term, bits 3:2 pick the Y term |
| logic_mode | input | 1 | 1 selects bitwise logic, 0 selects arithmetic |
| carry_in | input | 1 | Active-high carry into bit 0 |
| result | output | 4 | Operation result |
| carry_out | output | 1 | Active-high carry out of bit 3; 0 in logic mode |
| grp_prop | output | 1 | Group propagate for external lookahead |
| grp_gen | output | 1 | Group generate for external lookahead |
| all_ones | output | 1 | High when every result bit is 1 |

## Verification
The slice holds no state, so every output is due in the same cycle as the inputs that cause it, after nothing more than logic settling. The bench changes the inputs just after a rising clock edge and reads every output at the following falling edge. Each check therefore sees values that have fully settled, and none depends on the order of events at an edge. An exhaustive sweep over all operands, function codes, modes and carry values runs alongside a short table of hand-computed vectors.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int SEL_W = 4;

    typedef enum logic {
        MODE_ARITH = 1'b0,
        MODE_LOGIC = 1'b1
    } mode_e;

    // Function code split into the two per-bit term pickers.
    typedef struct packed {
        logic [1:0] y_pick;   // code bits 3:2
        logic [1:0] x_pick;   // code bits 1:0
    } sel_t;

    // X term of one bit position: the "propagate" candidate.
    function automatic logic x_term(input logic a, input logic b, input logic [1:0] pick);
        logic r;
        case (pick)
            2'b00:   r = a;
            2'b01:   r = a | b;
            2'b10:   r = a | ~b;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

    // Y term of one bit position: the "generate" candidate (never set without X).
    function automatic logic y_term(input logic a, input logic b, input logic [1:0] pick);
        logic r;
        case (pick)
            2'b00:   r = 1'b0;
            2'b01:   r = a & ~b;
            2'b10:   r = a & b;
            default: r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu4_terms.sv
module alu4_terms
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  sel_t             sel_i,
    output logic [WIDTH-1:0] xt_o,
    output logic [WIDTH-1:0] yt_o
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            assign xt_o[gi] = x_term(a_i[gi], b_i[gi], sel_i.x_pick);
            assign yt_o[gi] = y_term(a_i[gi], b_i[gi], sel_i.y_pick);
        end
    endgenerate

endmodule

// File: rtl/alu4_lookahead.sv
module alu4_lookahead #(
    parameter int WIDTH = 4,
    localparam int CW = WIDTH + 1
) (
    input  logic [WIDTH-1:0] xt_i,
    input  logic [WIDTH-1:0] yt_i,
    input  logic             cin_i,
    output logic [CW-1:0]    carry_o,
    output logic             gprop_o,
    output logic             ggen_o
);

    assign carry_o[0] = cin_i;

    // Each carry is formed directly from the terms below it (flat lookahead).
    genvar gk;
    generate
        for (gk = 1; gk < CW; gk++) begin : g_carry
            logic gen_acc;
            logic run_prop;
            always_comb begin
                gen_acc  = 1'b0;
                run_prop = 1'b1;
                for (int j = gk - 1; j >= 0; j--) begin
                    gen_acc  = gen_acc | (yt_i[j] & run_prop);
                    run_prop = run_prop & xt_i[j];
                end
            end
            assign carry_o[gk] = gen_acc | (run_prop & cin_i);
        end
    endgenerate

    // Group flags exclude the carry input.
    assign gprop_o = &xt_i;
    assign ggen_o  = g_carry[WIDTH].gen_acc;

endmodule

// File: rtl/alu4_result.sv
module alu4_result
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] xt_i,
    input  logic [WIDTH-1:0] yt_i,
    input  logic [WIDTH-1:0] carry_i,
    input  mode_e            mode_i,
    output logic [WIDTH-1:0] result_o,
    output logic             all_ones_o
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic inject;
            // Logic mode pins every internal carry high, which turns the
            // half-sum into its complement and cuts any dependence on carries.
            assign inject       = (mode_i == MODE_LOGIC) ? 1'b1 : carry_i[gi];
            assign result_o[gi] = xt_i[gi] ^ yt_i[gi] ^ inject;
        end
    endgenerate

    assign all_ones_o = &result_o;

endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [SEL_W-1:0] func_sel,
    input  logic             logic_mode,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             grp_prop,
    output logic             grp_gen,
    output logic             all_ones
);

    localparam int CW = WIDTH + 1;

    sel_t             sel;
    mode_e            mode;
    logic [WIDTH-1:0] xt;
    logic [WIDTH-1:0] yt;
    logic [CW-1:0]    carry_vec;

    assign sel  = sel_t'(func_sel);
    assign mode = mode_e'(logic_mode);

    alu4_terms #(.WIDTH(WIDTH)) u_terms (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .sel_i (sel),
        .xt_o  (xt),
        .yt_o  (yt)
    );

    alu4_lookahead #(.WIDTH(WIDTH)) u_carry (
        .xt_i    (xt),
        .yt_i    (yt),
        .cin_i   (carry_in),
        .carry_o (carry_vec),
        .gprop_o (grp_prop),
        .ggen_o  (grp_gen)
    );

    alu4_result #(.WIDTH(WIDTH)) u_out (
        .xt_i       (xt),
        .yt_i       (yt),
        .carry_i    (carry_vec[WIDTH-1:0]),
        .mode_i     (mode),
        .result_o   (result),
        .all_ones_o (all_ones)
    );

    assign carry_out = (mode == MODE_ARITH) ? carry_vec[WIDTH] : 1'b0;

endmodule

// File: rtl/alu4_slice_chk.sv
module alu4_slice_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [3:0]       func_sel,
    input logic             logic_mode,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             grp_prop,
    input logic             grp_gen,
    input logic             all_ones
);

    always_comb begin
        // R5: no carry leaves the slice in logic mode
        p_logic_no_carry_r5: assert (!(logic_mode && carry_out));
        // R8: flag tracks the result bits
        p_flag_all_ones_r8: assert (all_ones == (result == {WIDTH{1'b1}}));
        // R6: a group generate always produces a carry in arithmetic mode
        p_gen_forces_carry_r6: assert (!(!logic_mode && grp_gen && !carry_out));
        // R7: full propagate with carry in produces a carry in arithmetic mode
        p_prop_passes_carry_r7: assert (!(!logic_mode && grp_prop && carry_in && !carry_out));
        // R8: decrement-subtract gives all ones exactly on equal operands
        p_equal_operands_r8: assert (logic_mode || carry_in || func_sel != 4'h6
                                     || (all_ones == (opnd_a == opnd_b)));
        // R9: subtract carry marks A >= B
        p_no_borrow_r9: assert (logic_mode || !carry_in || func_sel != 4'h6
                                || (carry_out == (opnd_a >= opnd_b)));
    end

endmodule

bind alu4_slice alu4_slice_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .func_sel   (func_sel),
    .logic_mode (logic_mode),
    .carry_in   (carry_in),
    .result     (result),
    .carry_out  (carry_out),
    .grp_prop   (grp_prop),
    .grp_gen    (grp_gen),
    .all_ones   (all_ones)
);

// File: tb/alu4_slice_tb.sv
module alu4_slice_tb;

    logic       clk = 1'b0;
    logic [3:0] opnd_a = '0;
    logic [3:0] opnd_b = '0;
    logic [3:0] func_sel = '0;
    logic       logic_mode = 1'b0;
    logic       carry_in = 1'b0;
    logic [3:0] result;
    logic       carry_out, grp_prop, grp_gen, all_ones;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    alu4_slice u_dut (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .func_sel   (func_sel),
        .logic_mode (logic_mode),
        .carry_in   (carry_in),
        .result     (result),
        .carry_out  (carry_out),
        .grp_prop   (grp_prop),
        .grp_gen    (grp_gen),
        .all_ones   (all_ones)
    );

    // Vector: {mode, code, cin, a, b, exp_result, exp_cout, exp_flag}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 4'h9, 1'b0, 4'h3, 4'h4, 4'h7, 1'b0, 1'b0},
        {1'b0, 4'h9, 1'b1, 4'hF, 4'h0, 4'h0, 1'b1, 1'b0},
        {1'b0, 4'h6, 1'b0, 4'h5, 4'h5, 4'hF, 1'b0, 1'b1},
        {1'b0, 4'h6, 1'b1, 4'h7, 4'h2, 4'h5, 1'b1, 1'b0},
        {1'b0, 4'h6, 1'b1, 4'h2, 4'h7, 4'hB, 1'b0, 1'b0},
        {1'b1, 4'h6, 1'b0, 4'hC, 4'hA, 4'h6, 1'b0, 1'b0},
        {1'b1, 4'h9, 1'b1, 4'hC, 4'hA, 4'h9, 1'b0, 1'b0},
        {1'b1, 4'h3, 1'b0, 4'hF, 4'hF, 4'h0, 1'b0, 1'b0},
        {1'b1, 4'hC, 1'b1, 4'h0, 4'h0, 4'hF, 1'b0, 1'b1},
        {1'b0, 4'hC, 1'b1, 4'h9, 4'h0, 4'h3, 1'b1, 1'b0},
        {1'b0, 4'hF, 1'b0, 4'h0, 4'h6, 4'hF, 1'b0, 1'b1},
        {1'b0, 4'h0, 1'b1, 4'hF, 4'h3, 4'h0, 1'b1, 1'b0},
        {1'b1, 4'h0, 1'b1, 4'h5, 4'h9, 4'hA, 1'b0, 1'b0},
        {1'b0, 4'h3, 1'b1, 4'h8, 4'h1, 4'h0, 1'b1, 1'b0}
    };

    function automatic logic [4:0] ref_xy(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
        logic [3:0] x, y;
        case (s)
            4'h0: begin x = a;       y = 4'h0;    end
            4'h1: begin x = a | b;   y = 4'h0;    end
            4'h2: begin x = a | ~b;  y = 4'h0;    end
            4'h3: begin x = 4'hF;    y = 4'h0;    end
            4'h4: begin x = a;       y = a & ~b;  end
            4'h5: begin x = a | b;   y = a & ~b;  end
            4'h6: begin x = a;       y = ~b;      end
            4'h7: begin x = a & ~b;  y = 4'hF;    end
            4'h8: begin x = a;       y = a & b;   end
            4'h9: begin x = a;       y = b;       end
            4'hA: begin x = a | ~b;  y = a & b;   end
            4'hB: begin x = a & b;   y = 4'hF;    end
            4'hC: begin x = a;       y = a;       end
            4'hD: begin x = a | b;   y = a;       end
            4'hE: begin x = a | ~b;  y = a;       end
            default: begin x = a;    y = 4'hF;    end
        endcase
        return {1'b0, x} + {1'b0, y};
    endfunction

    function automatic logic [3:0] ref_logic(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
        case (s)
            4'h0: return ~a;
            4'h1: return ~(a | b);
            4'h2: return ~a & b;
            4'h3: return 4'h0;
            4'h4: return ~(a & b);
            4'h5: return ~b;
            4'h6: return a ^ b;
            4'h7: return a & ~b;
            4'h8: return ~a | b;
            4'h9: return ~(a ^ b);
            4'hA: return b;
            4'hB: return a & b;
            4'hC: return 4'hF;
            4'hD: return a | ~b;
            4'hE: return a | b;
            default: return a;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (m=%0b s=%h cin=%0b a=%h b=%h)",
                     req, act, exp, logic_mode, func_sel, carry_in, opnd_a, opnd_b);
        end
    endtask

    task automatic apply(input logic m, input logic [3:0] s, input logic c,
                         input logic [3:0] a, input logic [3:0] b);
        @(posedge clk);
        logic_mode = m; func_sel = s; carry_in = c; opnd_a = a; opnd_b = b;
        @(negedge clk);
    endtask

    // Full check of the current inputs against the reference.
    task automatic check_all();
        logic [4:0] xy;
        logic [4:0] sum;
        xy  = ref_xy(func_sel, opnd_a, opnd_b);
        sum = xy + {4'b0, carry_in};
        if (logic_mode) begin
            chk(carry_in ? "R5 result ignores cin" : "R1 logic result",
                int'(result), int'(ref_logic(func_sel, opnd_a, opnd_b)));
            chk("R5 cout low in logic", int'(carry_out), 0);
        end else begin
            chk(carry_in ? "R3 arith result plus one" : "R2 arith result",
                int'(result), int'(sum[3:0]));
            chk("R4 arith carry out", int'(carry_out), int'(sum[4]));
            if (func_sel == 4'h6 && carry_in)
                chk("R9 subtract order", int'(carry_out), int'(opnd_a >= opnd_b));
            if (func_sel == 4'h6 && !carry_in)
                chk("R8 equal operands", int'(all_ones), int'(opnd_a == opnd_b));
        end
        chk("R8 all ones flag", int'(all_ones), int'(result == 4'hF));
        chk("R6 group generate", int'(grp_gen), int'(xy >= 5'd16));
        chk("R7 group propagate", int'(grp_gen | grp_prop), int'(xy >= 5'd15));
    endtask

    initial begin
        // Initial state: all inputs zero, code 0 arithmetic gives A = 0.
        @(negedge clk);
        chk("R2 initial result", int'(result), 0);
        chk("R4 initial carry", int'(carry_out), 0);
        chk("R8 initial flag", int'(all_ones), 0);

        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            apply(v[19], v[18:15], v[14], v[13:10], v[9:6]);
            chk(v[19] ? "R1 vector result" : (v[14] ? "R3 vector result" : "R2 vector result"),
                int'(result), int'(v[5:2]));
            chk(v[19] ? "R5 vector carry" : "R4 vector carry", int'(carry_out), int'(v[1]));
            chk("R8 vector flag", int'(all_ones), int'(v[0]));
        end

        for (int n = 0; n < 16384; n++) begin
            logic [13:0] w;
            w = 14'(n);
            apply(w[13], w[11:8], w[12], w[3:0], w[7:4]);
            check_all();
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule